// File: doc/BRIEF.md
# Display Power-Up Sequencer with Panel Detection

After reset, this block brings up one of two kinds of display panel. It works through a register access master that sits next to it. The block first asks that master for a read of panel register 0x00. It compares the returned word with a fixed identity value, and the result selects the panel variant. It then runs that variant's power-up program. A program is an ordered list of register writes, with timed pauses placed between some of the writes. When the last step has finished, the block raises a ready flag.

Once ready is high, a one-cycle pulse on the display-off input runs the variant's power-down program, and a pulse on the display-on input runs the power-up program. Each program is a small constant table inside the block. Each table entry is a write, a pause or an end marker. The sequencer moves to the next entry when the access master reports that the write is done, or when the pause counter expires.

Pause lengths are counted in units. The number of clock cycles in one unit is a parameter, so a simulation can use a small value and silicon can use a large one.

Top module: `dps_sequencer`

## Requirements
- R1: While reset is held, `req_valid`, `ready` and `panel_alt` are all 0.
- R2: The first request after reset is a read (`req_write`=0) of register 0x00. No read is issued once `ready` is high.
- R3: `panel_alt` is updated in the cycle the read completes. It becomes 0 when `acc_rdata` equals 0x0139 and 1 for any other value, and it holds that value until the next reset.
- R4: A request keeps `req_valid`, `req_write`, `req_addr` and `req_wdata` steady until `acc_done`. `req_valid` is low in the cycle after `acc_done`, and the next request can rise one cycle later.
- R5: The variant-0 power-up program issues these writes, given here as register←value with pauses in units:
  - 0x07←0, then 0x13←0, then a 1-unit pause.
  - 0x11←0x3304, 0x14←0x1300, 0x10←0x1A20, 0x13←0x0040, then a 5-unit pause.
  - 0x13←0x0060, 0x13←0x0070, then a 20-unit pause.
  - 0x01←0x0127, 0x03←0x1030, 0x07←0x0015, then a 3-unit pause.
  - 0x07←0x0017, then 0x20←0, 0x21←0, 0x22←0.
- R6: The variant-1 power-up program issues these writes:
  - 0x07←0, 0x12←0, then a 1-unit pause.
  - 0x11←0x000C, 0x12←0x0A1C, 0x10←0x7404, then a 5-unit pause.
  - 0x07←0x0009, 0x12←0x065C, then a 20-unit pause.
  - 0x07←0x0009, a 4-unit pause, 0x07←0x0109, a 4-unit pause, then 0x07←0x010B.
- R7: A pause of m units between two writes makes the next request rise m·UNIT_CYCLES+2 cycles after the previous `acc_done` cycle. Without a pause the gap is 1 cycle.
- R8: `ready` rises one cycle after the `acc_done` of the last power-up write, and it stays high until reset.
- R9: Display-on and display-off pulses that arrive before `ready` is high have no effect. No requests follow them.
- R10: The power-down programs are as follows:
  - Variant 0: 0x07←0x0016, a 4-unit pause, 0x07←0x0004, a 4-unit pause, 0x10←0x1E21, then a 1-unit pause.
  - Variant 1: 0x0B←0x0109, 0x07←0x0009, a 4-unit pause, 0x07←0x0008, a 4-unit pause, 0x10←0x0400, 0x10←0x0401, then a 1-unit pause.
- R11: The display-on programs are as follows:
  - Variant 0: 0x00←0x0001, a 1-unit pause, 0x10←0, a 1-unit pause, 0x11←0x3304, 0x14←0x1300, 0x10←0x1A20, 0x07←0x0015, a 3-unit pause, 0x07←0x0017, then 0x20, 0x21 and 0x22 ←0.
  - Variant 1: 0x10←0x0400, a 4-unit pause, 0x07←0, 0x12←0, a 1-unit pause, 0x10←0x7404, a 5-unit pause, 0x07←0x0009, a 4-unit pause, 0x07←0x0109, a 4-unit pause, then 0x07←0x010B.
- R12: A pulse that arrives while a program is running is held in one pending slot and starts only after the current program ends. A later pulse replaces an earlier one. When on and off pulse in the same cycle, off is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| on_req | input | 1 | One-cycle pulse: run the display-on program |
| off_req | input | 1 | One-cycle pulse: run the display-off program |
| req_valid | output | 1 | Request to the access master is pending |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | 8 | Panel register index |
| req_wdata | output | 16 | Write value |
| acc_done | input | 1 | Access master finished the pending request (one cycle) |
| acc_rdata | input | 16 | Read result, valid with `acc_done` |
| ready | output | 1 | Power-up program finished |
| panel_alt | output | 1 | 0 = identity matched 0x0139, 1 = other panel |

## Verification
The bench records the cycle index of each `acc_done` and of each request's rising edge. It checks these gaps against R7:
- one cycle between two writes with no pause between them;
- m·UNIT_CYCLES+2 cycles when a pause of m units lies between them.

`panel_alt` is checked in the same half-cycle in which the identity read's done is logged. `ready` is checked at two points: low at the half-cycle in which the last power-up write's done is logged, and high one cycle later. All outputs are sampled a short delay after the falling edge, and the bench's access-master model also acts on the falling edge, so each registered result is read one full register stage after the edge that produced it.

// File: rtl/dps_pkg.sv
// Shared types for the display power-up sequencer.
// Assumes register indices of 8 bits and register values of 16 bits.
package dps_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam int IDX_W  = 5;
    localparam logic [DATA_W-1:0] ID_MATCH = 16'h0139;

    typedef enum logic [1:0] {
        K_WRITE = 2'd0,
        K_PAUSE = 2'd1,
        K_END   = 2'd2
    } step_kind_t;

    typedef enum logic [2:0] {
        PRG_UP0   = 3'd0,
        PRG_UP1   = 3'd1,
        PRG_ON0   = 3'd2,
        PRG_ON1   = 3'd3,
        PRG_OFF0  = 3'd4,
        PRG_OFF1  = 3'd5
    } prog_t;

    typedef struct packed {
        step_kind_t          kind;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   val;   // write value, or pause length in units
    } step_t;

    function automatic step_t wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] v);
        step_t s;
        s.kind = K_WRITE;
        s.addr = a;
        s.val  = v;
        return s;
    endfunction

    function automatic step_t pause(input logic [DATA_W-1:0] units);
        step_t s;
        s.kind = K_PAUSE;
        s.addr = '0;
        s.val  = units;
        return s;
    endfunction

    function automatic step_t fin();
        step_t s;
        s.kind = K_END;
        s.addr = '0;
        s.val  = '0;
        return s;
    endfunction

endpackage

// File: rtl/dps_step_rom.sv
// Constant program tables: returns the step at (program, index).
// Assumes every program ends with an END entry before index 2**IDX_W.
module dps_step_rom
    import dps_pkg::*;
(
    input  prog_t             prog,
    input  logic [IDX_W-1:0]  idx,
    output step_t             step
);

    // Table lookup for the selected program.
    always_comb begin
        step = fin();
        unique case (prog)
            PRG_UP0: begin
                case (idx)
                    5'd0:  step = wr(8'h07, 16'h0000);
                    5'd1:  step = wr(8'h13, 16'h0000);
                    5'd2:  step = pause(16'd1);
                    5'd3:  step = wr(8'h11, 16'h3304);
                    5'd4:  step = wr(8'h14, 16'h1300);
                    5'd5:  step = wr(8'h10, 16'h1A20);
                    5'd6:  step = wr(8'h13, 16'h0040);
                    5'd7:  step = pause(16'd5);
                    5'd8:  step = wr(8'h13, 16'h0060);
                    5'd9:  step = wr(8'h13, 16'h0070);
                    5'd10: step = pause(16'd20);
                    5'd11: step = wr(8'h01, 16'h0127);
                    5'd12: step = wr(8'h03, 16'h1030);
                    5'd13: step = wr(8'h07, 16'h0015);
                    5'd14: step = pause(16'd3);
                    5'd15: step = wr(8'h07, 16'h0017);
                    5'd16: step = wr(8'h20, 16'h0000);
                    5'd17: step = wr(8'h21, 16'h0000);
                    5'd18: step = wr(8'h22, 16'h0000);
                    default: step = fin();
                endcase
            end
            PRG_UP1: begin
                case (idx)
                    5'd0:  step = wr(8'h07, 16'h0000);
                    5'd1:  step = wr(8'h12, 16'h0000);
                    5'd2:  step = pause(16'd1);
                    5'd3:  step = wr(8'h11, 16'h000C);
                    5'd4:  step = wr(8'h12, 16'h0A1C);
                    5'd5:  step = wr(8'h10, 16'h7404);
                    5'd6:  step = pause(16'd5);
                    5'd7:  step = wr(8'h07, 16'h0009);
                    5'd8:  step = wr(8'h12, 16'h065C);
                    5'd9:  step = pause(16'd20);
                    5'd10: step = wr(8'h07, 16'h0009);
                    5'd11: step = pause(16'd4);
                    5'd12: step = wr(8'h07, 16'h0109);
                    5'd13: step = pause(16'd4);
                    5'd14: step = wr(8'h07, 16'h010B);
                    default: step = fin();
                endcase
            end
            PRG_ON0: begin
                case (idx)
                    5'd0:  step = wr(8'h00, 16'h0001);
                    5'd1:  step = pause(16'd1);
                    5'd2:  step = wr(8'h10, 16'h0000);
                    5'd3:  step = pause(16'd1);
                    5'd4:  step = wr(8'h11, 16'h3304);
                    5'd5:  step = wr(8'h14, 16'h1300);
                    5'd6:  step = wr(8'h10, 16'h1A20);
                    5'd7:  step = wr(8'h07, 16'h0015);
                    5'd8:  step = pause(16'd3);
                    5'd9:  step = wr(8'h07, 16'h0017);
                    5'd10: step = wr(8'h20, 16'h0000);
                    5'd11: step = wr(8'h21, 16'h0000);
                    5'd12: step = wr(8'h22, 16'h0000);
                    default: step = fin();
                endcase
            end
            PRG_ON1: begin
                case (idx)
                    5'd0:  step = wr(8'h10, 16'h0400);
                    5'd1:  step = pause(16'd4);
                    5'd2:  step = wr(8'h07, 16'h0000);
                    5'd3:  step = wr(8'h12, 16'h0000);
                    5'd4:  step = pause(16'd1);
                    5'd5:  step = wr(8'h10, 16'h7404);
                    5'd6:  step = pause(16'd5);
                    5'd7:  step = wr(8'h07, 16'h0009);
                    5'd8:  step = pause(16'd4);
                    5'd9:  step = wr(8'h07, 16'h0109);
                    5'd10: step = pause(16'd4);
                    5'd11: step = wr(8'h07, 16'h010B);
                    default: step = fin();
                endcase
            end
            PRG_OFF0: begin
                case (idx)
                    5'd0:  step = wr(8'h07, 16'h0016);
                    5'd1:  step = pause(16'd4);
                    5'd2:  step = wr(8'h07, 16'h0004);
                    5'd3:  step = pause(16'd4);
                    5'd4:  step = wr(8'h10, 16'h1E21);
                    5'd5:  step = pause(16'd1);
                    default: step = fin();
                endcase
            end
            PRG_OFF1: begin
                case (idx)
                    5'd0:  step = wr(8'h0B, 16'h0109);
                    5'd1:  step = wr(8'h07, 16'h0009);
                    5'd2:  step = pause(16'd4);
                    5'd3:  step = wr(8'h07, 16'h0008);
                    5'd4:  step = pause(16'd4);
                    5'd5:  step = wr(8'h10, 16'h0400);
                    5'd6:  step = wr(8'h10, 16'h0401);
                    5'd7:  step = pause(16'd1);
                    default: step = fin();
                endcase
            end
            default: step = fin();
        endcase
    end

endmodule

// File: rtl/dps_pause_timer.sv
// Down-counter for pauses: loaded with units*UNIT_CYCLES, flags the last cycle.
// Assumes units >= 1 and units <= MAX_UNITS.
module dps_pause_timer #(
    parameter int UNIT_CYCLES = 1000,
    parameter int MAX_UNITS   = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [15:0] units,
    output logic        expired
);

    localparam int CNT_W = $clog2(MAX_UNITS * UNIT_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    // Load on request, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CNT_W'(32'(units) * 32'(UNIT_CYCLES));
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expired = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/dps_req_hold.sv
// Single-slot holder for on/off pulses; a later pulse overrides, off beats on.
// Assumes pulses are accepted only while accept_en is high.
module dps_req_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic accept_en,
    input  logic on_pulse,
    input  logic off_pulse,
    input  logic take,
    output logic pend_valid,
    output logic pend_off
);

    // Capture a new pulse, or clear the slot when the sequencer takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_off   <= 1'b0;
        end else if (accept_en && (on_pulse || off_pulse)) begin
            pend_valid <= 1'b1;
            pend_off   <= off_pulse;
        end else if (take) begin
            pend_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/dps_sequencer.sv
// Top: identity read, variant selection, table-driven write/pause programs.
// Assumes the access master holds acc_done high for one cycle per request.
module dps_sequencer
    import dps_pkg::*;
#(
    parameter int UNIT_CYCLES = 1000,
    parameter int MAX_UNITS   = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              on_req,
    input  logic              off_req,
    output logic              req_valid,
    output logic              req_write,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_wdata,
    input  logic              acc_done,
    input  logic [DATA_W-1:0] acc_rdata,
    output logic              ready,
    output logic              panel_alt
);

    typedef enum logic [2:0] {
        S_ID_REQ, S_ID_WAIT, S_ISSUE, S_ACCESS, S_PAUSE, S_IDLE
    } state_t;

    state_t           state_q;
    prog_t            prog_q;
    logic [IDX_W-1:0] idx_q;
    step_t            cur_step;
    logic             timer_load;
    logic             timer_expired;
    logic             pend_valid;
    logic             pend_off;
    logic             take;

    dps_step_rom u_rom (
        .prog (prog_q),
        .idx  (idx_q),
        .step (cur_step)
    );

    dps_pause_timer #(
        .UNIT_CYCLES (UNIT_CYCLES),
        .MAX_UNITS   (MAX_UNITS)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (timer_load),
        .units   (cur_step.val),
        .expired (timer_expired)
    );

    dps_req_hold u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_en  (ready),
        .on_pulse   (on_req),
        .off_pulse  (off_req),
        .take       (take),
        .pend_valid (pend_valid),
        .pend_off   (pend_off)
    );

    assign timer_load = (state_q == S_ISSUE) && (cur_step.kind == K_PAUSE);
    assign take       = (state_q == S_IDLE) && pend_valid;

    // Main sequencing state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_ID_REQ;
            prog_q    <= PRG_UP0;
            idx_q     <= '0;
            req_valid <= 1'b0;
            req_write <= 1'b0;
            req_addr  <= '0;
            req_wdata <= '0;
            ready     <= 1'b0;
            panel_alt <= 1'b0;
        end else begin
            unique case (state_q)
                S_ID_REQ: begin
                    req_valid <= 1'b1;
                    req_write <= 1'b0;
                    req_addr  <= '0;
                    req_wdata <= '0;
                    state_q   <= S_ID_WAIT;
                end
                S_ID_WAIT: begin
                    if (acc_done) begin
                        req_valid <= 1'b0;
                        panel_alt <= (acc_rdata != ID_MATCH);
                        prog_q    <= (acc_rdata != ID_MATCH) ? PRG_UP1 : PRG_UP0;
                        idx_q     <= '0;
                        state_q   <= S_ISSUE;
                    end
                end
                S_ISSUE: begin
                    unique case (cur_step.kind)
                        K_WRITE: begin
                            req_valid <= 1'b1;
                            req_write <= 1'b1;
                            req_addr  <= cur_step.addr;
                            req_wdata <= cur_step.val;
                            state_q   <= S_ACCESS;
                        end
                        K_PAUSE: state_q <= S_PAUSE;
                        default: begin
                            ready   <= 1'b1;
                            state_q <= S_IDLE;
                        end
                    endcase
                end
                S_ACCESS: begin
                    if (acc_done) begin
                        req_valid <= 1'b0;
                        idx_q     <= idx_q + IDX_W'(1);
                        state_q   <= S_ISSUE;
                    end
                end
                S_PAUSE: begin
                    if (timer_expired) begin
                        idx_q   <= idx_q + IDX_W'(1);
                        state_q <= S_ISSUE;
                    end
                end
                S_IDLE: begin
                    if (pend_valid) begin
                        if (pend_off) prog_q <= panel_alt ? PRG_OFF1 : PRG_OFF0;
                        else          prog_q <= panel_alt ? PRG_ON1  : PRG_ON0;
                        idx_q   <= '0;
                        state_q <= S_ISSUE;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dps_sequencer_chk.sv
// Protocol checker for dps_sequencer, attached with bind below.
// Assumes acc_done comes only while req_valid is high.
module dps_sequencer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [7:0]  req_addr,
    input logic [15:0] req_wdata,
    input logic        acc_done,
    input logic        ready,
    input logic        panel_alt
);

    // Pending request is held steady until done (R4).
    assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !acc_done) |=> (req_valid && $stable(req_addr)
                                      && $stable(req_wdata) && $stable(req_write)));

    // Request drops after done (R4).
    assert_gap_after_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && acc_done) |=> !req_valid);

    // Reads only happen before ready (R2).
    assert_read_before_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |-> !ready);

    // Ready is sticky (R8).
    assert_ready_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // Panel variant frozen once ready (R3).
    assert_variant_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> $stable(panel_alt));

endmodule

bind dps_sequencer dps_sequencer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .acc_done  (acc_done),
    .ready     (ready),
    .panel_alt (panel_alt)
);

// File: tb/tb_dps_sequencer.sv
// Directed bench for dps_sequencer with a falling-edge access-master model.
module tb_dps_sequencer;

    localparam int PERIOD = 10;
    localparam int UNIT   = 3;
    localparam int LAT    = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        on_req = 1'b0;
    logic        off_req = 1'b0;
    logic        req_valid;
    logic        req_write;
    logic [7:0]  req_addr;
    logic [15:0] req_wdata;
    logic        acc_done = 1'b0;
    logic [15:0] acc_rdata = 16'h0000;
    logic        ready;
    logic        panel_alt;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    bit finished = 0;

    int          log_n = 0;
    logic [7:0]  log_addr [128];
    logic [15:0] log_data [128];
    logic        log_wr   [128];
    int          log_rise [128];
    int          log_done [128];

    logic [7:0]  exp_a [32];
    logic [15:0] exp_d [32];
    int          exp_m [32];
    int          exp_n;

    dps_sequencer #(.UNIT_CYCLES(UNIT), .MAX_UNITS(20)) dut (
        .clk(clk), .rst_n(rst_n), .on_req(on_req), .off_req(off_req),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .acc_done(acc_done), .acc_rdata(acc_rdata),
        .ready(ready), .panel_alt(panel_alt)
    );

    initial forever #(PERIOD/2) clk = ~clk;
    initial forever begin @(posedge clk); cyc++; end

    // Access-master model: answers after LAT falling edges, logs each transfer.
    initial begin
        bit serving;
        int lat_cnt;
        serving = 0;
        lat_cnt = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                acc_done = 1'b0;
                serving = 0;
            end else if (acc_done) begin
                acc_done = 1'b0;
                log_done[log_n] = cyc;
                log_n++;
            end else if (req_valid) begin
                if (!serving) begin
                    serving = 1;
                    lat_cnt = 0;
                    log_addr[log_n] = req_addr;
                    log_data[log_n] = req_wdata;
                    log_wr[log_n]   = req_write;
                    log_rise[log_n] = cyc;
                end
                lat_cnt++;
                if (lat_cnt >= LAT) begin
                    acc_done = 1'b1;
                    serving = 0;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    task automatic wait_log(input int target, input string tag);
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk); #2;
            if (log_n >= target) return;
        end
        chk({tag, " timeout"}, log_n, target);
    endtask

    task automatic add(input logic [7:0] a, input logic [15:0] d, input int m);
        exp_a[exp_n] = a;
        exp_d[exp_n] = d;
        exp_m[exp_n] = m;
        exp_n++;
    endtask

    // Expected write lists; m = pause units before the write.
    task automatic load_exp(input int prg);
        exp_n = 0;
        case (prg)
            0: begin // variant-0 power-up (R5)
                add(8'h07,16'h0000,0); add(8'h13,16'h0000,0); add(8'h11,16'h3304,1);
                add(8'h14,16'h1300,0); add(8'h10,16'h1A20,0); add(8'h13,16'h0040,0);
                add(8'h13,16'h0060,5); add(8'h13,16'h0070,0); add(8'h01,16'h0127,20);
                add(8'h03,16'h1030,0); add(8'h07,16'h0015,0); add(8'h07,16'h0017,3);
                add(8'h20,16'h0000,0); add(8'h21,16'h0000,0); add(8'h22,16'h0000,0);
            end
            1: begin // variant-1 power-up (R6)
                add(8'h07,16'h0000,0); add(8'h12,16'h0000,0); add(8'h11,16'h000C,1);
                add(8'h12,16'h0A1C,0); add(8'h10,16'h7404,0); add(8'h07,16'h0009,5);
                add(8'h12,16'h065C,0); add(8'h07,16'h0009,20); add(8'h07,16'h0109,4);
                add(8'h07,16'h010B,4);
            end
            2: begin // variant-0 on (R11)
                add(8'h00,16'h0001,0); add(8'h10,16'h0000,1); add(8'h11,16'h3304,1);
                add(8'h14,16'h1300,0); add(8'h10,16'h1A20,0); add(8'h07,16'h0015,0);
                add(8'h07,16'h0017,3); add(8'h20,16'h0000,0); add(8'h21,16'h0000,0);
                add(8'h22,16'h0000,0);
            end
            3: begin // variant-1 on (R11)
                add(8'h10,16'h0400,0); add(8'h07,16'h0000,4); add(8'h12,16'h0000,0);
                add(8'h10,16'h7404,1); add(8'h07,16'h0009,5); add(8'h07,16'h0109,4);
                add(8'h07,16'h010B,4);
            end
            4: begin // variant-0 off (R10)
                add(8'h07,16'h0016,0); add(8'h07,16'h0004,4); add(8'h10,16'h1E21,4);
            end
            default: begin // variant-1 off (R10)
                add(8'h0B,16'h0109,0); add(8'h07,16'h0009,0); add(8'h07,16'h0008,4);
                add(8'h10,16'h0400,4); add(8'h10,16'h0401,0);
            end
        endcase
    endtask

    // Waits for a whole program at log position base and checks contents and gaps (R7).
    task automatic check_prog(input int base, input string tag);
        wait_log(base + exp_n, tag);
        for (int i = 0; i < exp_n; i++) begin
            chk({tag, " write"}, {7'd0, log_wr[base+i], log_addr[base+i], log_data[base+i]},
                {7'd0, 1'b1, exp_a[i], exp_d[i]});
            if (i > 0)
                chk("R7 gap", log_rise[base+i] - log_done[base+i-1],
                    (exp_m[i] > 0) ? exp_m[i] * UNIT + 2 : 1);
        end
    endtask

    task automatic pulse(input bit on, input bit off);
        @(negedge clk);
        on_req = on;
        off_req = off;
        @(negedge clk);
        on_req = 1'b0;
        off_req = 1'b0;
    endtask

    task automatic quiet_check(input int expect_n, input string tag);
        repeat (150) @(negedge clk);
        #2;
        chk(tag, log_n, expect_n);
    endtask

    task automatic t_reset(input logic [15:0] id);
        rst_n = 1'b0;
        acc_rdata = id;
        repeat (3) @(negedge clk);
        #2;
        chk("R1 req_valid", req_valid, 0);
        chk("R1 ready", ready, 0);
        chk("R1 panel_alt", panel_alt, 0);
        log_n = 0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Identity read, variant choice, power-up program, ready timing.
    task automatic t_powerup(input logic [15:0] id, input bit alt);
        t_reset(id);
        fork
            begin
                repeat (8) @(negedge clk);
                pulse(1, 0);  // R9: ignored, not ready yet
                pulse(0, 1);
            end
        join_none
        wait_log(1, "R2");
        chk("R2 first is read", log_wr[0], 0);
        chk("R2 read reg 0", log_addr[0], 8'h00);
        chk("R3 variant", panel_alt, alt);
        load_exp(alt ? 1 : 0);
        check_prog(1, alt ? "R6" : "R5");
        chk("R8 ready low at last done", ready, 0);
        @(negedge clk); #2;
        chk("R8 ready high", ready, 1);
        quiet_check(1 + exp_n, "R9 early pulses ignored");
        chk("R3 variant held", panel_alt, alt);
    endtask

    // Off, with an on pulse arriving mid-program that must wait (R12).
    task automatic t_off_then_on(input bit alt);
        int base;
        int off_n;
        base = log_n;
        pulse(0, 1);
        wait_log(base + 1, "R10 start");
        pulse(1, 0);
        load_exp(alt ? 5 : 4);
        off_n = exp_n;
        check_prog(base, "R10");
        load_exp(alt ? 3 : 2);
        check_prog(base + off_n, "R11 held then run R12");
        quiet_check(base + off_n + exp_n, "R12 no extra program");
    endtask

    // Simultaneous on and off: only off runs (R12).
    task automatic t_both();
        int base;
        base = log_n;
        pulse(1, 1);
        load_exp(4);
        check_prog(base, "R12 off wins");
        quiet_check(base + exp_n, "R12 single program");
    endtask

    initial begin
        t_powerup(16'h0139, 1'b0);
        t_off_then_on(1'b0);
        t_both();
        t_powerup(16'h0138, 1'b1);
        t_off_then_on(1'b1);
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule